// File: doc/BRIEF.md
# Interrupt Controller Programming Front End

This block is the register side of an eight-input programmable interrupt controller attached to an 8-bit processor I/O bus. It accepts bus writes and sorts them into initialization words and operation commands. It steps through the initialization words in a fixed order and holds the interrupt mask. It also captures the request and in-service vectors that the rest of the controller presents on pins, so that software can read them back.

The bus has two ports. The command port (address bit 0 low) takes the first initialization word and the second and third operation commands. The data port (address bit 0 high) takes the later initialization words and, outside initialization, the mask. The stored words drive outputs toward the priority and vectoring logic, which is outside this block. Reads are combinational. The command port returns request or in-service status, chosen by a field of the third operation command. The data port returns the mask.

Top module: `pic_prog_front`

## Requirements
- R1: Only address bit 0 chooses the port (0 = command port, 1 = data port); address bit 1 has no effect, so offsets 0/2 and 1/3 behave identically.
- R2: A command-port write with data bit 4 set stores the first initialization word, clears the mask to 0x00, selects the request register for command-port reads and restarts the initialization sequence.
- R3: A command-port write with data bit 4 clear is decoded on bits 4:3: 00 stores the second operation command, 01 stores the third operation command.
- R4: After the first initialization word, the next three data-port writes are taken in order as the second, third and fourth initialization words and do not touch the mask; the sequence then ends.
- R5: The fourth initialization word is stored only if bit 0 of the first initialization word is 1; otherwise that write is dropped and the error flag is set.
- R6: When no initialization sequence is running, every data-port write loads the mask register.
- R7: A command-port read returns the request register when bits 1:0 of the third operation command are 10 and the in-service register when they are 11; with 00 or 01 it keeps returning the register last selected.
- R8: A data-port read always returns the mask register.
- R9: Reset (synchronous, active low) clears the request, in-service and mask registers and the error flag, ends any sequence and selects request status; dout is 0x00 whenever no read is under way.
- R10: The request and in-service registers capture their input pins on every clock edge, so a pin change is readable one cycle later.
- R11: The error flag stays set until reset or the next first initialization word.
- R12: Bus writes with chip select low change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all registers on rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select |
| addr | input | 2 | Port offset |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| din | input | DW | Write data |
| dout | output | DW | Read data, 0x00 when not reading |
| req_pins | input | DW | Raw interrupt request vector |
| isr_pins | input | DW | In-service vector from the priority logic |
| init_w1 | output | DW | First initialization word |
| init_w2 | output | DW | Second initialization word |
| init_w3 | output | DW | Third initialization word |
| init_w4 | output | DW | Fourth initialization word |
| cmd2 | output | DW | Second operation command |
| cmd3 | output | DW | Third operation command |
| mask_o | output | DW | Interrupt mask |
| err_o | output | 1 | Sticky initialization slot error |

## Verification
The bench builds the block with its default 8-bit data width, which places every decoded field (bit 4 marker, bits 4:3 command type, bits 1:0 read select, bit 0 fourth-word enable) on a real bus bit. That makes both initialization paths reachable, with the fourth word enabled and disabled, along with all four read-select codes and the alias offsets. With the request and in-service pins held at distinct patterns, each read shows at once which register the mux chose.

// File: rtl/pic_fe_pkg.sv
// Shared definitions for the interrupt controller programming front end.
// Assumes an 8-bit or wider bus; field positions below are fixed by the
// command word formats and do not scale with the data width.
package pic_fe_pkg;

    // initialization sequencer states; SEQ_IDLE means no sequence running
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_W2   = 2'd1,
        SEQ_W3   = 2'd2,
        SEQ_W4   = 2'd3
    } seq_state_t;

    // decoded bus strobes for one cycle
    typedef struct packed {
        logic wr_init;   // first initialization word on command port
        logic wr_cmd2;   // second operation command
        logic wr_cmd3;   // third operation command
        logic wr_data;   // any data-port write
        logic rd_cmd;    // command-port read
        logic rd_data;   // data-port read
    } bus_dec_t;

    localparam int unsigned INIT_MARK_BIT = 4;  // marks the first init word
    localparam int unsigned CMD_TYPE_LO   = 3;  // bits 4:3 pick the command
    localparam int unsigned W4_EN_BIT     = 0;  // in first word: fourth word present
    localparam int unsigned RSEL_VALID    = 1;  // in cmd3: selection is valid
    localparam int unsigned RSEL_ISR      = 0;  // in cmd3: 1 selects in-service
    localparam logic [1:0]  PORT_SEL_MASK = 2'b01; // offsets alias on bit 1

endpackage

// File: rtl/pic_fe_decode.sv
// Bus decoder: turns chip select, offset, strobes and the command-type bits
// of the write data into one-cycle strobes. Purely combinational.
// Assumes rd and wr are never active together.
module pic_fe_decode
    import pic_fe_pkg::*;
(
    input  logic       cs,
    input  logic [1:0] addr,
    input  logic       rd,
    input  logic       wr,
    input  logic [1:0] type_bits,   // write data bits 4:3
    output bus_dec_t   dec
);
    logic port_data;

    // port choice uses only the masked offset so aliases behave the same
    always_comb port_data = (addr & PORT_SEL_MASK) != 2'b00;

    // strobe generation
    always_comb begin
        dec         = '0;
        dec.wr_init = cs && wr && !port_data && type_bits[1];
        dec.wr_cmd2 = cs && wr && !port_data && (type_bits == 2'b00);
        dec.wr_cmd3 = cs && wr && !port_data && (type_bits == 2'b01);
        dec.wr_data = cs && wr && port_data;
        dec.rd_cmd  = cs && rd && !port_data;
        dec.rd_data = cs && rd && port_data;
    end
endmodule

// File: rtl/pic_fe_init_seq.sv
// Initialization sequencer: stores the four initialization words in order,
// gates the fourth on the enable bit of the first, flags a write into a
// disabled slot, and tells the mask logic when data-port writes are free.
// Assumes wr_init and wr_data are never active in the same cycle.
module pic_fe_init_seq
    import pic_fe_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_init,
    input  logic          wr_data,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] w1,
    output logic [DW-1:0] w2,
    output logic [DW-1:0] w3,
    output logic [DW-1:0] w4,
    output logic          seq_active,
    output logic          mask_load,
    output logic          err
);
    seq_state_t state;

    // sequence state, word storage and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            w1    <= '0;
            w2    <= '0;
            w3    <= '0;
            w4    <= '0;
            err   <= 1'b0;
        end else if (wr_init) begin
            w1    <= din;
            state <= SEQ_W2;
            err   <= 1'b0;
        end else if (wr_data) begin
            case (state)
                SEQ_W2: begin
                    w2    <= din;
                    state <= SEQ_W3;
                end
                SEQ_W3: begin
                    w3    <= din;
                    state <= SEQ_W4;
                end
                SEQ_W4: begin
                    if (w1[W4_EN_BIT]) w4  <= din;
                    else               err <= 1'b1;
                    state <= SEQ_IDLE;
                end
                default: ;
            endcase
        end
    end

    // sequence status toward the mask logic
    always_comb begin
        seq_active = (state != SEQ_IDLE);
        mask_load  = wr_data && (state == SEQ_IDLE);
    end
endmodule

// File: rtl/pic_fe_cmd_regs.sv
// Operation command registers: mask, second and third commands, and the
// remembered read selection for the command port.
// Assumes the strobes come from pic_fe_decode and are mutually exclusive.
module pic_fe_cmd_regs
    import pic_fe_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_init,
    input  logic          wr_cmd2,
    input  logic          wr_cmd3,
    input  logic          mask_load,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] mask,
    output logic [DW-1:0] cmd2,
    output logic [DW-1:0] cmd3,
    output logic          sel_isr
);
    localparam logic [DW-1:0] CMD3_INIT = DW'(1) << RSEL_VALID; // selects request

    // mask register
    always_ff @(posedge clk) begin
        if (!rst_n)         mask <= '0;
        else if (wr_init)   mask <= '0;
        else if (mask_load) mask <= din;
    end

    // second operation command
    always_ff @(posedge clk) begin
        if (!rst_n)       cmd2 <= '0;
        else if (wr_cmd2) cmd2 <= din;
    end

    // third operation command and remembered read selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd3    <= CMD3_INIT;
            sel_isr <= 1'b0;
        end else if (wr_init) begin
            cmd3    <= CMD3_INIT;
            sel_isr <= 1'b0;
        end else if (wr_cmd3) begin
            cmd3 <= din;
            if (din[RSEL_VALID]) sel_isr <= din[RSEL_ISR];
        end
    end
endmodule

// File: rtl/pic_fe_capture.sv
// Status capture: one register per input line, loaded every cycle, cleared
// by reset. Assumes the pins are synchronous to clk.
module pic_fe_capture #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // per-line capture flop
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= pins[i];
        end
    end
endmodule

// File: rtl/pic_prog_front.sv
// Top of the programming front end: decoder, initialization sequencer,
// command registers, two status captures, and the combinational read mux.
// Assumes DW >= 5 so every decoded field exists on the bus.
module pic_prog_front
    import pic_fe_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic [1:0]    addr,
    input  logic          rd,
    input  logic          wr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    input  logic [DW-1:0] req_pins,
    input  logic [DW-1:0] isr_pins,
    output logic [DW-1:0] init_w1,
    output logic [DW-1:0] init_w2,
    output logic [DW-1:0] init_w3,
    output logic [DW-1:0] init_w4,
    output logic [DW-1:0] cmd2,
    output logic [DW-1:0] cmd3,
    output logic [DW-1:0] mask_o,
    output logic          err_o
);
    bus_dec_t      dec;
    logic          seq_active;
    logic          mask_load;
    logic          sel_isr;
    logic [DW-1:0] req_q;
    logic [DW-1:0] isr_q;

    pic_fe_decode u_dec (
        .cs        (cs),
        .addr      (addr),
        .rd        (rd),
        .wr        (wr),
        .type_bits (din[INIT_MARK_BIT:CMD_TYPE_LO]),
        .dec       (dec)
    );

    pic_fe_init_seq #(.DW(DW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_init    (dec.wr_init),
        .wr_data    (dec.wr_data),
        .din        (din),
        .w1         (init_w1),
        .w2         (init_w2),
        .w3         (init_w3),
        .w4         (init_w4),
        .seq_active (seq_active),
        .mask_load  (mask_load),
        .err        (err_o)
    );

    pic_fe_cmd_regs #(.DW(DW)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_init   (dec.wr_init),
        .wr_cmd2   (dec.wr_cmd2),
        .wr_cmd3   (dec.wr_cmd3),
        .mask_load (mask_load),
        .din       (din),
        .mask      (mask_o),
        .cmd2      (cmd2),
        .cmd3      (cmd3),
        .sel_isr   (sel_isr)
    );

    pic_fe_capture #(.N(DW)) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (req_pins),
        .q     (req_q)
    );

    pic_fe_capture #(.N(DW)) u_isr (
        .clk   (clk),
        .rst_n (rst_n),
        .pins  (isr_pins),
        .q     (isr_q)
    );

    // read data mux, zero when no read is addressed
    always_comb begin
        dout = '0;
        if (dec.rd_data)     dout = mask_o;
        else if (dec.rd_cmd) dout = sel_isr ? isr_q : req_q;
    end
endmodule

// File: rtl/pic_prog_front_chk.sv
// Property checker for pic_prog_front, attached by bind below.
module pic_prog_front_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs,
    input logic [1:0]    addr,
    input logic          rd,
    input logic          wr,
    input logic [DW-1:0] din,
    input logic [DW-1:0] dout,
    input logic [DW-1:0] req_pins,
    input logic [DW-1:0] req_q,
    input logic [DW-1:0] mask_o,
    input logic          err_o,
    input logic          seq_active
);
    logic init_wr;
    always_comb init_wr = cs && wr && !addr[0] && din[4];

    // R2: first initialization word clears mask and error
    a_r2_init_clears_mask: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> (mask_o == '0 && !err_o));

    // R6: data-port write outside a sequence lands in the mask
    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && addr[0] && !seq_active) |=> (mask_o == $past(din)));

    // R8: data-port read shows the mask
    a_r8_data_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && addr[0]) |-> (dout == mask_o));

    // R10: request register follows the pins one cycle later
    a_r10_capture: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (req_q == $past(req_pins)));

    // R11: error flag holds until a new first word
    a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !init_wr) |=> err_o);

    // R12: no chip select, no mask change
    a_r12_no_cs_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> $stable(mask_o));
endmodule

bind pic_prog_front pic_prog_front_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs         (cs),
    .addr       (addr),
    .rd         (rd),
    .wr         (wr),
    .din        (din),
    .dout       (dout),
    .req_pins   (req_pins),
    .req_q      (req_q),
    .mask_o     (mask_o),
    .err_o      (err_o),
    .seq_active (seq_active)
);

// File: tb/tb_pic_prog_front.sv
module tb_pic_prog_front;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs = 1'b0;
    logic [1:0]    addr = '0;
    logic          rd = 1'b0;
    logic          wr = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic [DW-1:0] req_pins = 8'hA5;
    logic [DW-1:0] isr_pins = 8'h3C;
    logic [DW-1:0] init_w1, init_w2, init_w3, init_w4, cmd2, cmd3, mask_o;
    logic          err_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pic_prog_front #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .rd(rd), .wr(wr),
        .din(din), .dout(dout), .req_pins(req_pins), .isr_pins(isr_pins),
        .init_w1(init_w1), .init_w2(init_w2), .init_w3(init_w3),
        .init_w4(init_w4), .cmd2(cmd2), .cmd3(cmd3), .mask_o(mask_o),
        .err_o(err_o)
    );

    // vector: [22:19] requirement, [18] read, [17:16] offset, [15:8] data, [7:0] expected
    localparam int NV = 14;
    localparam logic [22:0] VEC [NV] = '{
        {4'd2,  1'b0, 2'd0, 8'h13, 8'h00}, // R2 first word, fourth word enabled
        {4'd2,  1'b1, 2'd1, 8'h00, 8'h00}, // R2 mask cleared
        {4'd4,  1'b0, 2'd1, 8'h20, 8'h00}, // R4 second word
        {4'd1,  1'b0, 2'd3, 8'h04, 8'h00}, // R1 third word via alias
        {4'd5,  1'b0, 2'd1, 8'h01, 8'h00}, // R5 fourth word
        {4'd6,  1'b0, 2'd1, 8'h5A, 8'h00}, // R6 mask load
        {4'd8,  1'b1, 2'd3, 8'h00, 8'h5A}, // R8 mask read via alias
        {4'd7,  1'b1, 2'd0, 8'h00, 8'hA5}, // R7 request after first word
        {4'd3,  1'b0, 2'd2, 8'h0B, 8'h00}, // R3 cmd3 select in-service
        {4'd7,  1'b1, 2'd0, 8'h00, 8'h3C}, // R7 in-service
        {4'd7,  1'b0, 2'd0, 8'h08, 8'h00}, // R7 cmd3 code 00
        {4'd7,  1'b1, 2'd2, 8'h00, 8'h3C}, // R7 keeps in-service
        {4'd7,  1'b0, 2'd0, 8'h0A, 8'h00}, // R7 cmd3 code 10
        {4'd7,  1'b1, 2'd0, 8'h00, 8'hA5}  // R7 request again
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr_port(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; din = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_port(input logic [1:0] a, output logic [DW-1:0] got);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        #2 got = dout;
        cs = 1'b0; rd = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] got;
        repeat (3) @(negedge clk);
        // R9 reset state: registers clear while pins are active
        check("R9 mask in reset", mask_o, 8'h00);
        check("R9 err in reset", {7'd0, err_o}, 8'h00);
        check("R9 idle dout", dout, 8'h00);
        cs = 1'b1; rd = 1'b1; addr = 2'd0; #2;
        check("R9 request cleared in reset", dout, 8'h00);
        cs = 1'b0; rd = 1'b0;
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vector %0d", VEC[i][22:19], i);
            if (VEC[i][18]) begin
                rd_port(VEC[i][17:16], got);
                check(tag, got, VEC[i][7:0]);
            end else begin
                wr_port(VEC[i][17:16], VEC[i][15:8]);
            end
        end
        check("R4 second word", init_w2, 8'h20);
        check("R4 third word", init_w3, 8'h04);
        check("R5 fourth word stored", init_w4, 8'h01);
        check("R5 no error", {7'd0, err_o}, 8'h00);
        check("R3 cmd3 stored", cmd3, 8'h0A);

        // R3 second operation command
        wr_port(2'd0, 8'h60);
        check("R3 cmd2 stored", cmd2, 8'h60);

        // R12 write without chip select
        @(negedge clk); wr = 1'b1; addr = 2'd1; din = 8'hFF;
        @(negedge clk); wr = 1'b0;
        check("R12 mask unchanged", mask_o, 8'h5A);

        // R4 sequence without fourth word; R5 rejection
        wr_port(2'd0, 8'h12);
        check("R2 mask cleared again", mask_o, 8'h00);
        wr_port(2'd1, 8'h99);
        check("R4 data write goes to word 2 not mask", mask_o, 8'h00);
        check("R4 word 2 updated", init_w2, 8'h99);
        wr_port(2'd1, 8'h00);
        wr_port(2'd1, 8'h77);
        check("R5 fourth word rejected", init_w4, 8'h01);
        check("R5 error set", {7'd0, err_o}, 8'h01);
        wr_port(2'd1, 8'h33);
        check("R6 mask after sequence", mask_o, 8'h33);
        check("R11 error held", {7'd0, err_o}, 8'h01);
        wr_port(2'd2, 8'h11);
        check("R11 error cleared by first word", {7'd0, err_o}, 8'h00);

        // R10 pin capture latency
        @(negedge clk); req_pins = 8'h81;
        rd_port(2'd0, got);
        check("R10 request captured", got, 8'h81);

        // R9 reset mid-run
        wr_port(2'd1, 8'h00); wr_port(2'd1, 8'h00); wr_port(2'd1, 8'h00);
        wr_port(2'd1, 8'hC3);
        check("R6 mask before reset", mask_o, 8'hC3);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R9 mask after reset", mask_o, 8'h00);
        wr_port(2'd1, 8'h44);
        check("R9 sequence ended by reset", mask_o, 8'h44);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule